// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter Model

This block is a synthesizable behavioural model of the device side of a byte-wide parallel NOR flash. A host drives chip-enable, write-enable and output-enable strobes together with an address and a data byte. The model decodes the software-protected command sequences for byte program, sector erase, chip erase, identification entry and identification exit. The storage is a small register-file array, and a cycle counter stands in for program and erase time.

While an internal operation runs, any read returns status instead of data. Bit 7 is a polling bit and bit 6 inverts on every read. At all other times a read returns array contents, or identification codes when identification mode is active. Any write that does not match the expected step of a multi-write sequence sends the decoder back to read mode. This protection is always on and cannot be disabled.

The bus is a plain strobe interface with no valid/ready handshake and no back-pressure. The host must pace its own accesses: it finds out that an operation has finished by polling the status bits. Writes that arrive during a busy period are dropped.

Top module: `flash_cmd_model`

## Requirements
- R1: After reset the array holds 0xFF in every byte, no operation is busy, the block is in read mode, and `dout` is 0x00 whenever no read strobe (ce_n and oe_n both low) is present.
- R2: A write is taken only while ce_n and we_n are both low and oe_n is high. The write is acted on when that condition ends, using the address and data held during it. Strobes given with oe_n low change nothing.
- R3: The writes 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0, followed by one write of address/data, program that byte. The new value is the old value AND the data.
- R4: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then 0x30 at any address, set every byte of the SECTOR_BYTES-aligned sector that holds that address to 0xFF. No other byte changes.
- R5: The same five writes followed by 0x5555/0x10 set every byte of the array to 0xFF.
- R6: A write that does not match the expected step of a sequence returns the decoder to read mode. No operation starts, and later writes must begin the sequence again from its first step.
- R7: While a program is busy, a read returns the complement of the programmed data's bit 7 in bit 7, with bits 5..0 at zero. Once PROG_CYC cycles have passed, reads return the stored data.
- R8: While a sector or chip erase is busy, a read returns 0 in bit 7, with bits 5..0 at zero. After completion, bit 7 reads 1 from the erased bytes.
- R9: During any busy period, bit 6 of each read is the inverse of bit 6 of the previous read. When the operation ends the toggling stops, and repeated reads return equal values.
- R10: The sequence AA/55/0x90 (same addresses as R3) enters identification mode. There, address 0 reads 0xBF, address 1 reads the device code (0xD4 for arrays up to 64 Ki bytes, 0xD5 for 128 Ki, 0xD6 for 256 Ki, 0xD7 above), and other addresses read 0x00. The sequence AA/55/0xF0 leaves the mode.
- R11: Every write during a busy period is ignored, including the identification exit sequence. Identification mode therefore survives an exit sequence issued while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data, status or identification byte; 0x00 with no read strobe |

## Verification
The assertions take two things for granted. First, every write strobe lasts at least one clock cycle. Second, address and data stay steady for the whole strobe, so that a write is captured as a single event. The bench meets both by changing strobes only on falling clock edges and holding each write for two cycles. It also leaves a gap of two cycles between accesses, so each read and each write is seen as one distinct strobe. Busy windows are sized so that the status reads fall well inside them, and the bench waits well past them before it reads data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2
  } op_kind_e;

  typedef enum logic [2:0] {
    SQ_READ  = 3'd0,
    SQ_KEY1  = 3'd1,
    SQ_KEY2  = 3'd2,
    SQ_PADDR = 3'd3,
    SQ_ERS0  = 3'd4,
    SQ_ERS1  = 3'd5,
    SQ_ERS2  = 3'd6
  } seq_st_e;

  localparam logic [7:0] CODE_KEY_A  = 8'hAA;
  localparam logic [7:0] CODE_KEY_B  = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ESETUP = 8'h80;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_IDIN   = 8'h90;
  localparam logic [7:0] CODE_IDOUT  = 8'hF0;
  localparam logic [7:0] MFR_CODE    = 8'hBF;
endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              evt,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [7:0]        ev_data,
  output logic              prog_go,
  output logic              serase_go,
  output logic              cerase_go,
  output logic              id_mode
);
  localparam logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(16'h2AAA);

  seq_st_e st_q, st_d;
  logic    id_d;
  logic    take;
  logic    at_a, at_b;

  assign take = evt && !busy;
  assign at_a = (ev_addr == KEY_ADDR_A);
  assign at_b = (ev_addr == KEY_ADDR_B);

  always_comb begin
    st_d      = st_q;
    id_d      = id_mode;
    prog_go   = 1'b0;
    serase_go = 1'b0;
    cerase_go = 1'b0;
    if (take) begin
      st_d = SQ_READ;
      unique case (st_q)
        SQ_READ: if (at_a && ev_data == CODE_KEY_A) st_d = SQ_KEY1;
        SQ_KEY1: if (at_b && ev_data == CODE_KEY_B) st_d = SQ_KEY2;
        SQ_KEY2: begin
          if (at_a) begin
            case (ev_data)
              CODE_PROG:   st_d = SQ_PADDR;
              CODE_ESETUP: st_d = SQ_ERS0;
              CODE_IDIN:   id_d = 1'b1;
              CODE_IDOUT:  id_d = 1'b0;
              default:     st_d = SQ_READ;
            endcase
          end
        end
        SQ_PADDR: prog_go = 1'b1;
        SQ_ERS0: if (at_a && ev_data == CODE_KEY_A) st_d = SQ_ERS1;
        SQ_ERS1: if (at_b && ev_data == CODE_KEY_B) st_d = SQ_ERS2;
        SQ_ERS2: begin
          if (at_a && ev_data == CODE_CHIP) cerase_go = 1'b1;
          else if (ev_data == CODE_SECT)    serase_go = 1'b1;
        end
        default: st_d = SQ_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_READ;
      id_mode <= 1'b0;
    end else begin
      st_q    <= st_d;
      id_mode <= id_d;
    end
  end

  // R6
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(st_q));
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PROG_CYC   = 16,
  parameter int SERASE_CYC = 32,
  parameter int CERASE_CYC = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic              serase_go,
  input  logic              cerase_go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [7:0]        go_data,
  output logic              busy,
  output logic              done,
  output op_kind_e          kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  localparam int MAX_CYC = (PROG_CYC > SERASE_CYC)
                         ? ((PROG_CYC > CERASE_CYC) ? PROG_CYC : CERASE_CYC)
                         : ((SERASE_CYC > CERASE_CYC) ? SERASE_CYC : CERASE_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             go_any;

  assign go_any = prog_go || serase_go || cerase_go;
  assign done   = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      kind    <= OP_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else if (go_any && !busy) begin
      busy    <= 1'b1;
      op_addr <= go_addr;
      op_data <= go_data;
      if (prog_go) begin
        kind  <= OP_PROG;
        cnt_q <= CNT_W'(PROG_CYC - 1);
      end else if (serase_go) begin
        kind  <= OP_SERASE;
        cnt_q <= CNT_W'(SERASE_CYC - 1);
      end else begin
        kind  <= OP_CERASE;
        cnt_q <= CNT_W'(CERASE_CYC - 1);
      end
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R11
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |-> !busy);
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int SECTOR_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_en,
  input  op_kind_e                 op_kind,
  input  logic [$clog2(DEPTH)-1:0] op_idx,
  input  logic [7:0]               op_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [7:0]               rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem_q [DEPTH];

  assign rd_data = mem_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (op_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        unique case (op_kind)
          OP_PROG:   if (i == int'(op_idx)) mem_q[i] <= mem_q[i] & op_data;
          OP_SERASE: if ((i / SECTOR_BYTES) == (int'(op_idx) / SECTOR_BYTES))
                       mem_q[i] <= 8'hFF;
          OP_CERASE: mem_q[i] <= 8'hFF;
          default:   mem_q[i] <= mem_q[i];
        endcase
      end
    end
  end

  // R3
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_kind == OP_PROG) |=> ((mem_q[$past(op_idx)] & ~$past(rd_data)) == 8'h00)
      || ($past(rd_idx) != $past(op_idx)));
endmodule

// File: rtl/flash_cmd_model.sv
module flash_cmd_model
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int MEM_DEPTH    = 256,
  parameter int SECTOR_BYTES = 16,
  parameter int PROG_CYC     = 16,
  parameter int SERASE_CYC   = 32,
  parameter int CERASE_CYC   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout
);
  localparam int MEM_AW = $clog2(MEM_DEPTH);
  localparam logic [7:0] DEV_CODE = (MEM_AW <= 16) ? 8'hD4 :
                                    (MEM_AW == 17) ? 8'hD5 :
                                    (MEM_AW == 18) ? 8'hD6 : 8'hD7;

  logic              wr_act, wr_q, wr_evt;
  logic              rd_act, rd_q, rd_end;
  logic [ADDR_W-1:0] cap_addr;
  logic [7:0]        cap_data;
  logic              prog_go, serase_go, cerase_go;
  logic              id_mode, busy, done;
  op_kind_e          kind;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic [7:0]        arr_data;
  logic              tog_q;
  logic              poll_bit;
  logic [7:0]        id_data;
  logic [7:0]        rd_val;

  assign wr_act = !ce_n && !we_n && oe_n;
  assign rd_act = !ce_n && !oe_n;
  assign wr_evt = wr_q && !wr_act;
  assign rd_end = rd_q && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
      tog_q    <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act) begin
        cap_addr <= addr;
        cap_data <= din;
      end
      if (rd_end && busy) tog_q <= !tog_q;
    end
  end

  flash_seq_decode #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .evt(wr_evt),
    .ev_addr(cap_addr), .ev_data(cap_data),
    .prog_go(prog_go), .serase_go(serase_go), .cerase_go(cerase_go),
    .id_mode(id_mode)
  );

  flash_busy_timer #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC),
    .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
  ) tmr_i (
    .clk(clk), .rst_n(rst_n),
    .prog_go(prog_go), .serase_go(serase_go), .cerase_go(cerase_go),
    .go_addr(cap_addr), .go_data(cap_data),
    .busy(busy), .done(done), .kind(kind),
    .op_addr(op_addr), .op_data(op_data)
  );

  flash_byte_array #(.DEPTH(MEM_DEPTH), .SECTOR_BYTES(SECTOR_BYTES)) arr_i (
    .clk(clk), .rst_n(rst_n), .op_en(done), .op_kind(kind),
    .op_idx(op_addr[MEM_AW-1:0]), .op_data(op_data),
    .rd_idx(done ? op_addr[MEM_AW-1:0] : addr[MEM_AW-1:0]),
    .rd_data(arr_data)
  );

  assign poll_bit = (kind == OP_PROG) ? !op_data[7] : 1'b0;
  assign id_data  = (addr == '0)             ? MFR_CODE :
                    (addr == ADDR_W'(1))     ? DEV_CODE : 8'h00;

  always_comb begin
    if (busy)         rd_val = {poll_bit, tog_q, 6'b000000};
    else if (id_mode) rd_val = id_data;
    else              rd_val = arr_data;
  end

  assign dout = rd_act ? rd_val : 8'h00;

  // R6
  op_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_evt));

  // R11
  id_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(id_mode));

  // R1
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |-> (dout == 8'h00));
endmodule

// File: tb/flash_cmd_model_tb_top.sv
module flash_cmd_model_tb_top;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        din = '0;
  logic [7:0]        dout;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = !clk;

  flash_cmd_model dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic oe_lvl = 1'b1);
    @(negedge clk);
    addr = a; din = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk); @(negedge clk);
    oe_n = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, cmd);
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    check("R1 idle bus", dout, 8'h00);
    rd(16'h0010, v); check("R1 array erased", v, 8'hFF);
    rd(16'h00FF, v); check("R1 top byte", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v1, v2;
    unlock(8'hA0); wr(16'h0020, 8'h5A);
    rd(16'h0020, v1); rd(16'h0020, v2);
    check("R7 busy poll", v1 & 8'hBF, 8'h80);
    check("R9 toggle", v2, v1 ^ 8'h40);
    settle();
    rd(16'h0020, v1); check("R3 program", v1, 8'h5A);
    rd(16'h0020, v2); check("R9 toggle stopped", v2, v1);
    unlock(8'hA0); wr(16'h0020, 8'hF0);
    settle();
    rd(16'h0020, v1); check("R3 and-only", v1, 8'h50);
  endtask

  task automatic t_oe_low();
    logic [7:0] v;
    wr(16'h5555, 8'hAA, 1'b0); wr(16'h2AAA, 8'h55, 1'b0);
    wr(16'h5555, 8'hA0, 1'b0); wr(16'h0030, 8'h00, 1'b0);
    settle();
    rd(16'h0030, v); check("R2 oe low ignored", v, 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h54);
    wr(16'h5555, 8'hA0); wr(16'h0040, 8'h00);
    rd(16'h0040, v); check("R6 abort no busy", v, 8'hFF);
    settle();
    rd(16'h0040, v); check("R6 abort no write", v, 8'hFF);
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h11); wr(16'h0020, 8'h30);
    settle();
    rd(16'h0020, v); check("R6 erase abort", v, 8'h50);
  endtask

  task automatic t_sector();
    logic [7:0] v1, v2;
    unlock(8'hA0); wr(16'h0025, 8'h00); settle();
    unlock(8'hA0); wr(16'h0035, 8'h00); settle();
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h002C, 8'h30);
    rd(16'h0025, v1); rd(16'h0025, v2);
    check("R8 sector busy", v1 & 8'hBF, 8'h00);
    check("R9 erase toggle", v2, v1 ^ 8'h40);
    settle();
    rd(16'h0025, v1); check("R4 sector byte", v1, 8'hFF);
    rd(16'h0020, v1); check("R4 sector start", v1, 8'hFF);
    rd(16'h0035, v1); check("R4 other sector", v1, 8'h00);
  endtask

  task automatic t_chip();
    logic [7:0] v;
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h10);
    rd(16'h0035, v); check("R8 chip busy", v & 8'hBF, 8'h00);
    settle();
    rd(16'h0035, v); check("R5 chip erased", v, 8'hFF);
    check("R8 done bit7", v & 8'h80, 8'h80);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    unlock(8'hA0); wr(16'h0050, 8'h0F); settle();
    unlock(8'h90);
    rd(16'h0000, v); check("R10 maker", v, 8'hBF);
    rd(16'h0001, v); check("R10 device", v, 8'hD4);
    rd(16'h0050, v); check("R10 other", v, 8'h00);
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h0070, 8'h30);
    unlock(8'hF0);
    settle();
    rd(16'h0000, v); check("R11 exit ignored busy", v, 8'hBF);
    unlock(8'hF0);
    rd(16'h0050, v); check("R10 exit array", v, 8'h0F);
    rd(16'h0000, v); check("R10 exit addr0", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_oe_low();
    t_abort();
    t_sector();
    t_chip();
    t_ident();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule